// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, from the 48-bit destination address at the head of an incoming frame, whether the frame is kept. The receive path pulses `frame_start` when a new frame begins and then presents the header one byte per `byte_valid` cycle. The block keeps the first six bytes as the destination address. While those bytes arrive it also runs a CRC-32 over them, which is used later for the multicast hash check.

Once the sixth byte has been taken, the block applies four rules to the address, in a fixed order:

1. Promiscuous override.
2. Exact match against the programmed station address.
3. The all-ones broadcast address.
4. A 64-bit multicast hash filter.

The block registers one accept verdict, plus a flag that names the first rule that hit. Both hold until the next frame start. The station address arrives as three 16-bit words packed into `station_regs`, with word k in bits 16k+15:16k. The filter arrives as four 16-bit words packed into `hash_regs` the same way.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `result_valid`, `accept` and all four hit flags are 0.
- R2: Only cycles with `byte_valid` high and `frame_start` low deliver an address byte. Idle cycles in between are skipped. A byte presented in the same cycle as `frame_start` is dropped. The verdict becomes valid in the cycle after the sixth delivered byte.
- R3: A verdict holds unchanged while any further header bytes arrive, and it also holds with no traffic. `frame_start` clears `result_valid`, `accept` and the flags in the following cycle. A frame that delivers fewer than six bytes never raises `result_valid`.
- R4: With `ctl_promisc` high, every frame is accepted and `hit_promisc` is set.
- R5: The received byte k (k = 0 is the first on the wire) is compared with `station_regs[8k+7:8k]`. The low byte of each 16-bit word therefore comes before its high byte. A full six-byte match accepts the frame with `hit_station` set.
- R6: With `ctl_no_station` high, a station match is never reported. Broadcast and hash acceptance still apply.
- R7: A destination of six 0xFF bytes is accepted, with `hit_bcast` set.
- R8: The hash check is consulted only when bit 0 of the first destination byte is 1 and `hash_regs` is non-zero. The CRC-32 over the six bytes uses the reflected polynomial 0xEDB88320 and starts from all ones. Bytes are fed LSB first, and the final value is not inverted. The check takes bits 31..26 of the CRC as an index. It accepts with `hit_hash` set when `hash_regs[index]` is 1, which is byte index>>3, bit index&7, byte 0 being the low byte of word 0.
- R9: The rule priority is promiscuous, then station, then broadcast, then hash. At most one flag is set at a time, and `accept` is 1 exactly when a flag is set.
- R10: `station_regs`, `hash_regs` and the two control bits are sampled only in the cycle of the sixth byte. Changing them afterwards leaves the held verdict unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse marking the start of a new frame |
| byte_valid | input | 1 | Header byte present on byte_data |
| byte_data | input | 8 | Header byte, destination address first |
| station_regs | input | 48 | Station address, three 16-bit words |
| hash_regs | input | 64 | Multicast hash filter, four 16-bit words |
| ctl_promisc | input | 1 | Accept every frame |
| ctl_no_station | input | 1 | Suppress station-address matching |
| result_valid | output | 1 | Verdict for the current frame is ready |
| accept | output | 1 | Frame is accepted |
| hit_promisc | output | 1 | Accepted by promiscuous override |
| hit_station | output | 1 | Accepted by station-address match |
| hit_bcast | output | 1 | Accepted as broadcast |
| hit_hash | output | 1 | Accepted by multicast hash filter |

## Verification
The assertions check the following on every cycle:
- At most one hit flag is set, and nothing is accepted without a valid verdict.
- A frame start empties the verdict, and a held verdict stays stable.
- A sixth delivered byte always yields a verdict, and a promiscuous frame is always flagged as such.
- A station hit never follows a disabled station match, and a hash hit never comes from an all-zero filter.

Which rule should win for a given address depends on the exact byte order, the CRC index and the filter bit selection. Only the bench scenarios can show that. They compare each verdict against a separately computed model over directed corner cases and random addresses, filters and byte gaps.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

    typedef enum logic [2:0] {
        RULE_NONE    = 3'd0,
        RULE_PROMISC = 3'd1,
        RULE_STATION = 3'd2,
        RULE_BCAST   = 3'd3,
        RULE_HASH    = 3'd4
    } rule_e;

    typedef struct packed {
        logic  accept;
        rule_e rule;
    } verdict_t;

    // One byte of a reflected CRC-32, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] crc_in,
                                                  input logic [7:0]       data);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ data[i];
            c  = {1'b0, c[CRC_W-1:1]} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_byte_capture.sv
module rxf_byte_capture #(
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W    = ADDR_BYTES * 8,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              take,
    output logic              last,
    output logic [ADDR_W-1:0] dest_now
);

    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;

    assign take = byte_valid && !frame_start && (cnt_q < CNT_W'(ADDR_BYTES));
    assign last = take && (cnt_q == CNT_W'(ADDR_BYTES - 1));

    // Stored bytes with the byte arriving this cycle merged into its slot.
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_slot
        assign dest_now[8*k +: 8] = (take && cnt_q == CNT_W'(k)) ? byte_data
                                                                 : addr_q[8*k +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (frame_start) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (take) begin
            cnt_q  <= cnt_q + 1'b1;
            addr_q <= dest_now;
        end
    end

endmodule

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 take,
    input  logic [7:0]           byte_data,
    output logic [HASH_BITS-1:0] hash_idx
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;

    assign crc_next = take ? crc_byte(crc_q, byte_data) : crc_q;
    assign hash_idx = crc_next[CRC_W-1 -: HASH_BITS];

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            crc_q <= CRC_INIT;
        end else begin
            crc_q <= crc_next;
        end
    end

endmodule

// File: rtl/rxf_rule_eval.sv
module rxf_rule_eval
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int ADDR_W    = ADDR_BYTES * 8,
    localparam int FILT_W    = 1 << HASH_BITS
) (
    input  logic [ADDR_W-1:0]    dest,
    input  logic [HASH_BITS-1:0] hash_idx,
    input  logic [ADDR_W-1:0]    station_regs,
    input  logic [FILT_W-1:0]    hash_regs,
    input  logic                 ctl_promisc,
    input  logic                 ctl_no_station,
    output verdict_t             verdict
);

    logic is_station;
    logic is_bcast;
    logic is_hash;

    assign is_station = !ctl_no_station && (dest == station_regs);
    assign is_bcast   = &dest;
    assign is_hash    = dest[0] && (|hash_regs) && hash_regs[hash_idx];

    always_comb begin
        verdict.accept = 1'b1;
        if (ctl_promisc)     verdict.rule = RULE_PROMISC;
        else if (is_station) verdict.rule = RULE_STATION;
        else if (is_bcast)   verdict.rule = RULE_BCAST;
        else if (is_hash)    verdict.rule = RULE_HASH;
        else begin
            verdict.rule   = RULE_NONE;
            verdict.accept = 1'b0;
        end
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int ADDR_W    = ADDR_BYTES * 8,
    localparam int FILT_W    = 1 << HASH_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic [ADDR_W-1:0] station_regs,
    input  logic [FILT_W-1:0] hash_regs,
    input  logic              ctl_promisc,
    input  logic              ctl_no_station,
    output logic              result_valid,
    output logic              accept,
    output logic              hit_promisc,
    output logic              hit_station,
    output logic              hit_bcast,
    output logic              hit_hash
);

    logic                 take;
    logic                 last;
    logic [ADDR_W-1:0]    dest_now;
    logic [HASH_BITS-1:0] hash_idx;
    verdict_t             verdict_now;
    verdict_t             verdict_q;
    logic                 valid_q;

    rxf_byte_capture #(.ADDR_BYTES(ADDR_BYTES)) u_capture (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .take        (take),
        .last        (last),
        .dest_now    (dest_now)
    );

    rxf_crc_hash #(.HASH_BITS(HASH_BITS)) u_crc (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .take        (take),
        .byte_data   (byte_data),
        .hash_idx    (hash_idx)
    );

    rxf_rule_eval #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_eval (
        .dest           (dest_now),
        .hash_idx       (hash_idx),
        .station_regs   (station_regs),
        .hash_regs      (hash_regs),
        .ctl_promisc    (ctl_promisc),
        .ctl_no_station (ctl_no_station),
        .verdict        (verdict_now)
    );

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            valid_q   <= 1'b0;
            verdict_q <= '{accept: 1'b0, rule: RULE_NONE};
        end else if (last) begin
            valid_q   <= 1'b1;
            verdict_q <= verdict_now;
        end
    end

    assign result_valid = valid_q;
    assign accept       = verdict_q.accept;
    assign hit_promisc  = (verdict_q.rule == RULE_PROMISC);
    assign hit_station  = (verdict_q.rule == RULE_STATION);
    assign hit_bcast    = (verdict_q.rule == RULE_BCAST);
    assign hit_hash     = (verdict_q.rule == RULE_HASH);

endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int ADDR_BYTES = 6,
    parameter int FILT_W     = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              byte_valid,
    input logic              ctl_promisc,
    input logic              ctl_no_station,
    input logic [FILT_W-1:0] hash_regs,
    input logic              result_valid,
    input logic              accept,
    input logic              hit_promisc,
    input logic              hit_station,
    input logic              hit_bcast,
    input logic              hit_hash
);

    logic [7:0] seen_q;
    logic       six_now;

    assign six_now = byte_valid && !frame_start && (seen_q == 8'(ADDR_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst || frame_start)                        seen_q <= '0;
        else if (byte_valid && seen_q < 8'(ADDR_BYTES)) seen_q <= seen_q + 8'd1;
    end

    // R9
    flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_promisc, hit_station, hit_bcast, hit_hash}));

    // R3
    no_accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> !accept && !hit_promisc && !hit_station && !hit_bcast && !hit_hash);

    // R3
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !result_valid);

    // R3
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid && !frame_start |=> result_valid && $stable(accept)
            && $stable({hit_promisc, hit_station, hit_bcast, hit_hash}));

    // R2
    sixth_byte_valid_chk: assert property (@(posedge clk) disable iff (rst)
        six_now |=> result_valid);

    // R4
    promisc_wins_chk: assert property (@(posedge clk) disable iff (rst)
        six_now && ctl_promisc |=> hit_promisc && accept);

    // R6
    station_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(result_valid) && hit_station |-> !$past(ctl_no_station));

    // R8
    hash_needs_filter_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(result_valid) && hit_hash |-> $past(|hash_regs));

endmodule

bind rx_addr_filter rxf_chk #(.ADDR_BYTES(ADDR_BYTES), .FILT_W(FILT_W)) u_rxf_chk (
    .clk            (clk),
    .rst            (rst),
    .frame_start    (frame_start),
    .byte_valid     (byte_valid),
    .ctl_promisc    (ctl_promisc),
    .ctl_no_station (ctl_no_station),
    .hash_regs      (hash_regs),
    .result_valid   (result_valid),
    .accept         (accept),
    .hit_promisc    (hit_promisc),
    .hit_station    (hit_station),
    .hit_bcast      (hit_bcast),
    .hit_hash       (hit_hash)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_start;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic [47:0] station_regs;
    logic [63:0] hash_regs;
    logic        ctl_promisc;
    logic        ctl_no_station;
    logic        result_valid;
    logic        accept;
    logic        hit_promisc;
    logic        hit_station;
    logic        hit_bcast;
    logic        hit_hash;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    rx_addr_filter dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .station_regs(station_regs), .hash_regs(hash_regs),
        .ctl_promisc(ctl_promisc), .ctl_no_station(ctl_no_station),
        .result_valid(result_valid), .accept(accept), .hit_promisc(hit_promisc),
        .hit_station(hit_station), .hit_bcast(hit_bcast), .hit_hash(hit_hash)
    );

    function automatic logic [31:0] ref_crc(input logic [47:0] d);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int n = 0; n < 48; n++) begin
            if (c[0] ^ d[n]) c = (c >> 1) ^ 32'hEDB88320;
            else             c = c >> 1;
        end
        return c;
    endfunction

    // Returns {hash, bcast, station, promisc}.
    function automatic logic [3:0] ref_flags(input logic [47:0] d);
        logic [5:0] idx;
        idx = ref_crc(d)[31:26];
        if (ctl_promisc)                         return 4'b0001;
        if (!ctl_no_station && d == station_regs) return 4'b0010;
        if (d == 48'hFFFF_FFFF_FFFF)             return 4'b0100;
        if (d[0] && hash_regs != 64'd0 && hash_regs[idx]) return 4'b1000;
        return 4'b0000;
    endfunction

    task automatic check(input string req, input logic exp_valid, input logic [3:0] exp_flags);
        logic [5:0] act, exp;
        act = {result_valid, accept, hit_hash, hit_bcast, hit_station, hit_promisc};
        exp = {exp_valid, exp_valid && (|exp_flags), exp_valid ? exp_flags : 4'b0000};
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got valid/accept/flags=%b expected %b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        byte_data  = 8'h00;
    endtask

    task automatic send_addr(input logic [47:0] d, input int max_gap);
        for (int k = 0; k < 6; k++) begin
            if (max_gap > 0) idle($urandom_range(max_gap, 0));
            put_byte(d[8*k +: 8]);
        end
    endtask

    task automatic frame(input string req, input logic [47:0] d, input int max_gap);
        pulse_start();
        send_addr(d, max_gap);
        check(req, 1'b1, ref_flags(d));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [47:0] a;
        logic [3:0]  held;
        logic [5:0]  idx;
        void'($urandom(32'd20240611));
        rst = 1'b1; frame_start = 1'b0; byte_valid = 1'b0; byte_data = 8'h00;
        station_regs = 48'h6655_4433_2211; hash_regs = 64'd0;
        ctl_promisc = 1'b0; ctl_no_station = 1'b0;
        idle(3);
        check("R1 reset", 1'b0, 4'b0000);
        rst = 1'b0;
        idle(1);
        check("R1 after reset", 1'b0, 4'b0000);

        // R5: bytes 11,22,33,44,55,66 on the wire match the low-byte-first words.
        frame("R5 station match", 48'h6655_4433_2211, 0);
        check("R5 station flag", 1'b1, 4'b0010);
        frame("R5 byte order swapped rejects", 48'h5566_3344_1122, 0);
        check("R5 swapped flag", 1'b1, 4'b0000);

        // R6
        ctl_no_station = 1'b1;
        frame("R6 station disabled", 48'h6655_4433_2211, 2);
        check("R6 disabled flag", 1'b1, 4'b0000);
        frame("R6 broadcast still accepted", 48'hFFFF_FFFF_FFFF, 0);
        ctl_no_station = 1'b0;

        // R7, R9: broadcast; station programmed to all ones wins over broadcast.
        frame("R7 broadcast", 48'hFFFF_FFFF_FFFF, 1);
        check("R7 bcast flag", 1'b1, 4'b0100);
        station_regs = 48'hFFFF_FFFF_FFFF;
        frame("R9 station beats broadcast", 48'hFFFF_FFFF_FFFF, 0);
        check("R9 station flag", 1'b1, 4'b0010);
        station_regs = 48'h6655_4433_2211;

        // R8: hash hit, miss, zero filter, unicast with full filter.
        a = 48'hA5C3_1E77_5B01;
        idx = ref_crc(a)[31:26];
        hash_regs = 64'd1 << idx;
        frame("R8 hash hit", a, 0);
        check("R8 hash flag", 1'b1, 4'b1000);
        hash_regs = ~(64'd1 << idx);
        frame("R8 hash miss", a, 0);
        check("R8 miss flag", 1'b1, 4'b0000);
        hash_regs = 64'd0;
        frame("R8 zero filter", a, 0);
        check("R8 zero flag", 1'b1, 4'b0000);
        hash_regs = ~64'd0;
        frame("R8 unicast skips hash", 48'hA5C3_1E77_5B02, 0);
        check("R8 unicast flag", 1'b1, 4'b0000);

        // R4, R9: promiscuous beats everything.
        ctl_promisc = 1'b1;
        frame("R4 promisc on station addr", 48'h6655_4433_2211, 0);
        check("R4 promisc flag", 1'b1, 4'b0001);
        frame("R4 promisc random", 48'h0102_0304_0506, 3);
        ctl_promisc = 1'b0;

        // R10, R3: change inputs and extra bytes after the verdict.
        hash_regs = 64'd0;
        frame("R10 base", 48'h6655_4433_2211, 0);
        held = 4'b0010;
        ctl_promisc = 1'b1; ctl_no_station = 1'b1; station_regs = 48'd0; hash_regs = ~64'd0;
        idle(2);
        check("R10 inputs changed after decision", 1'b1, held);
        for (int k = 0; k < 8; k++) put_byte(8'hFF);
        check("R3 trailing bytes ignored", 1'b1, held);
        pulse_start();
        check("R3 frame_start clears", 1'b0, 4'b0000);
        ctl_promisc = 1'b0; ctl_no_station = 1'b0;
        station_regs = 48'h6655_4433_2211; hash_regs = 64'd0;

        // R3: partial frame never yields a verdict.
        put_byte(8'h11); put_byte(8'h22); put_byte(8'h33);
        idle(3);
        check("R3 partial frame", 1'b0, 4'b0000);

        // R2: byte presented with frame_start is dropped.
        frame_start = 1'b1; byte_valid = 1'b1; byte_data = 8'hFF;
        @(negedge clk);
        frame_start = 1'b0; byte_valid = 1'b0;
        send_addr(48'h6655_4433_2211, 0);
        check("R2 byte with frame_start dropped", 1'b1, 4'b0010);

        // R2: five bytes give no verdict, the sixth does.
        pulse_start();
        for (int k = 0; k < 5; k++) put_byte(station_regs[8*k +: 8]);
        check("R2 five bytes not valid", 1'b0, 4'b0000);
        put_byte(station_regs[47:40]);
        check("R2 sixth byte valid", 1'b1, 4'b0010);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] mode;
            mode = 3'($urandom_range(4, 0));
            station_regs = {$urandom, $urandom};
            hash_regs = ($urandom_range(3, 0) == 0) ? 64'd0 : {$urandom, $urandom};
            ctl_promisc = ($urandom_range(7, 0) == 0);
            ctl_no_station = ($urandom_range(3, 0) == 0);
            case (mode)
                3'd0:    a = station_regs;
                3'd1:    a = 48'hFFFF_FFFF_FFFF;
                3'd2:    a = {$urandom, $urandom} | 48'd1;
                default: a = {$urandom, $urandom};
            endcase
            frame("R9 random frame", a, 2);
            if ($urandom_range(1, 0) == 1) begin
                put_byte(8'($urandom));
                check("R3 random trailing byte", 1'b1, ref_flags(a) & 4'hF);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule